// File: doc/BRIEF.md
# Backlight Dimming PWM Generator

This block produces one pulse-width-modulated output meant to drive a display backlight through an external low-pass filter. An 8-bit counter runs freely. It steps once per prescaled tick and wraps from 255 to 0, so one PWM period is 256 counter steps. A compare value sets how many of those steps are in the active phase. A polarity input sets whether the active phase is driven high or low. The prescaler divides its source by a power of two.

The source of prescaler ticks is picked by a select input. It is either every cycle of the block clock, or single-cycle pulses on an auxiliary tick input that come from a slower time base in the same clock domain. The compare value, the prescaler setting and the polarity are plain configuration inputs. They are copied into working registers only at the moment the counter wraps, so a period is never cut short or stretched by a change. The clock-source select acts at once. There is no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `bl_pwm`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the counter and the prescaler divider. It loads `cfg_cmp`, `cfg_psel` and `cfg_pol` into the working registers. At that same edge it drives `pwm_out` to the inactive level, which is `!cfg_pol`.
- R2: With working polarity 1, `pwm_out` at edge k+1 is high exactly when the counter value held between edges k and k+1 is less than the working compare value. A period therefore holds `cmp` high counter steps out of 256. With compare 255 that is 255 of 256 steps, and the step at count 255 is always inactive.
- R3: With working polarity 0, `pwm_out` is the complement of the R2 waveform, so a period holds 256 − `cmp` high counter steps.
- R4: A working compare value of 0 holds `pwm_out` at the inactive level for the whole period, with no pulse at the wrap.
- R5: The prescaler field N (`cfg_psel`, 3 bits, values 0 to 6) makes the counter advance once every 2^N source ticks. A full period is therefore 256·2^N source ticks.
- R6: A `cfg_psel` value of 7, which is above the highest setting 6, is treated as 6.
- R7: Changes to `cfg_cmp`, `cfg_psel` and `cfg_pol` reach the working registers only on the tick at which the counter wraps from 255 to 0. A period in progress ends with its old settings.
- R8: With `cfg_clksel` = 0 every clock cycle is a source tick. With `cfg_clksel` = 1 only the cycles with `aux_tick` high are source ticks, so without `aux_tick` pulses the counter and `pwm_out` stay frozen. The select takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cmp | input | 8 | Compare value requested for the next period |
| cfg_psel | input | 3 | Prescaler exponent requested for the next period (7 is treated as 6) |
| cfg_pol | input | 1 | Requested polarity: 1 gives active-high pulses, 0 gives active-low pulses |
| cfg_clksel | input | 1 | Tick source: 0 is every clock, 1 is `aux_tick` pulses |
| aux_tick | input | 1 | Auxiliary one-cycle tick pulses, same clock domain |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions check the following on every cycle:
- the counter steps by one on each prescaled tick and holds otherwise;
- the divider stays below 2^N;
- the working settings change only at a wrap;
- the output is inactive at count 255 and whenever the compare value is zero;
- no tick occurs while the auxiliary source is selected and idle.

A cycle-by-cycle scoreboard compares the output against a model built from the requirements. It adds exact high-cycle counts over whole periods for several compare values, both polarities, prescaler settings 0, 2 and 6, and the saturated setting 7. Those duty counts, the delay of a change mid-period until the wrap, and the frozen output with an idle auxiliary source show up only in those scenarios.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int BLP_CNT_W  = 8;
  localparam int BLP_PS_W   = 3;
  localparam int BLP_PS_MAX = 6;

  function automatic int clamp_ps(input int sel, input int lim);
    return (sel > lim) ? lim : sel;
  endfunction
endpackage

// File: rtl/bl_pwm_tick_gen.sv
module bl_pwm_tick_gen #(
  parameter int PS_W  = 3,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clksel,
  input  logic             aux_tick,
  input  logic [PS_W-1:0]  ps,
  output logic             tick,
  output logic [DIV_W-1:0] div_cnt
);
  logic             src_tick;
  logic [DIV_W-1:0] mask;

  assign src_tick = clksel ? aux_tick : 1'b1;
  assign mask     = ~({DIV_W{1'b1}} << ps);
  assign tick     = src_tick && ((div_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)           div_cnt <= '0;
    else if (tick)     div_cnt <= '0;
    else if (src_tick) div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_counter.sv
module bl_pwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_shadow.sv
module bl_pwm_shadow
  import bl_pwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PS_W   = 3,
  parameter int PS_MAX = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] cfg_cmp,
  input  logic [PS_W-1:0]  cfg_psel,
  input  logic             cfg_pol,
  output logic [CNT_W-1:0] act_cmp,
  output logic [PS_W-1:0]  act_ps,
  output logic             act_pol
);
  logic [PS_W-1:0] ps_sat;

  assign ps_sat = PS_W'(clamp_ps(int'(cfg_psel), PS_MAX));

  always_ff @(posedge clk) begin
    if (rst || load) begin
      act_cmp <= cfg_cmp;
      act_ps  <= ps_sat;
      act_pol <= cfg_pol;
    end
  end
endmodule

// File: rtl/bl_pwm_out_stage.sv
module bl_pwm_out_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             pol,
  output logic             pwm_out
);
  logic in_pulse;

  assign in_pulse = (cnt < cmp);

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= ~rst_pol;
    else     pwm_out <= pol ? in_pulse : ~in_pulse;
  end
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
  import bl_pwm_pkg::*;
#(
  parameter int CNT_W  = BLP_CNT_W,
  parameter int PS_W   = BLP_PS_W,
  parameter int PS_MAX = BLP_PS_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_cmp,
  input  logic [PS_W-1:0]  cfg_psel,
  input  logic             cfg_pol,
  input  logic             cfg_clksel,
  input  logic             aux_tick,
  output logic             pwm_out
);
  localparam int DIV_W = (PS_MAX < 1) ? 1 : PS_MAX;

  logic             tick;
  logic             wrap;
  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_cmp;
  logic [PS_W-1:0]  act_ps;
  logic             act_pol;

  bl_pwm_tick_gen #(.PS_W(PS_W), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .clksel(cfg_clksel), .aux_tick(aux_tick),
    .ps(act_ps), .tick(tick), .div_cnt(div_cnt)
  );

  bl_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .wrap(wrap)
  );

  bl_pwm_shadow #(.CNT_W(CNT_W), .PS_W(PS_W), .PS_MAX(PS_MAX)) u_shadow (
    .clk(clk), .rst(rst), .load(wrap),
    .cfg_cmp(cfg_cmp), .cfg_psel(cfg_psel), .cfg_pol(cfg_pol),
    .act_cmp(act_cmp), .act_ps(act_ps), .act_pol(act_pol)
  );

  bl_pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .rst_pol(cfg_pol),
    .cnt(cnt), .cmp(act_cmp), .pol(act_pol), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 3,
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_pol,
  input logic             cfg_clksel,
  input logic             aux_tick,
  input logic             pwm_out,
  input logic             tick,
  input logic [DIV_W-1:0] div_cnt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_cmp,
  input logic [PS_W-1:0]  act_ps,
  input logic             act_pol
);
  logic rst_q;
  logic pol_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    pol_q <= cfg_pol;
  end

  always @(posedge clk) begin
    if (rst_q == 1'b1) begin
      AST_RESET_STATE: assert (cnt == '0 && div_cnt == '0 && pwm_out == !pol_q); // R1
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == $past(cnt) + 1'b1); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt)); // R5
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    (div_cnt >> act_ps) == '0); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(tick && cnt == {CNT_W{1'b1}}) |=> $stable(act_cmp) && $stable(act_ps) && $stable(act_pol)); // R7
  AST_TOP_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    cnt == {CNT_W{1'b1}} |=> pwm_out == !$past(act_pol)); // R2
  AST_ZERO_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    act_cmp == '0 |=> pwm_out == !$past(act_pol)); // R4
  AST_AUX_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_clksel && !aux_tick) |-> !tick); // R8
endmodule

bind bl_pwm bl_pwm_chk #(.CNT_W(CNT_W), .PS_W(PS_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_pol(cfg_pol), .cfg_clksel(cfg_clksel),
  .aux_tick(aux_tick), .pwm_out(pwm_out), .tick(tick), .div_cnt(div_cnt),
  .cnt(cnt), .act_cmp(act_cmp), .act_ps(act_ps), .act_pol(act_pol)
);

// File: tb/bl_pwm_bench.sv
module bl_pwm_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_cmp = 8'd0;
  logic [2:0] cfg_psel = 3'd0;
  logic       cfg_pol = 1'b1;
  logic       cfg_clksel = 1'b0;
  logic       aux_tick = 1'b0;
  logic       pwm_out;

  bl_pwm u_bl_pwm (
    .clk(clk), .rst(rst), .cfg_cmp(cfg_cmp), .cfg_psel(cfg_psel),
    .cfg_pol(cfg_pol), .cfg_clksel(cfg_clksel), .aux_tick(aux_tick),
    .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_tag = "R1";
  bit    q_exp[$];

  // auxiliary tick source: one pulse every 4 clocks when enabled
  bit aux_en = 1'b0;
  int aux_ph = 0;
  always @(negedge clk) begin
    aux_ph = (aux_ph + 1) % 4;
    aux_tick <= aux_en && (aux_ph == 0);
  end

  // reference model from the requirements; pushes expected output per edge
  int m_cnt, m_div, m_cmp, m_ps, m_pol;
  always @(posedge clk) begin
    bit e;
    bit src;
    if (rst) begin
      m_cnt = 0; m_div = 0;
      m_cmp = cfg_cmp; m_ps = (cfg_psel > 6) ? 6 : int'(cfg_psel); m_pol = cfg_pol;
      e = !cfg_pol;
    end else begin
      e   = m_pol ? (m_cnt < m_cmp) : !(m_cnt < m_cmp);
      src = cfg_clksel ? aux_tick : 1'b1;
      if (src) begin
        if (m_div == (1 << m_ps) - 1) begin
          m_div = 0;
          if (m_cnt == 255) begin
            m_cnt = 0;
            m_cmp = cfg_cmp; m_ps = (cfg_psel > 6) ? 6 : int'(cfg_psel); m_pol = cfg_pol;
          end else m_cnt++;
        end else m_div++;
      end
    end
    q_exp.push_back(e);
  end

  // monitor: pops expected values and compares away from the edge
  always @(negedge clk) begin
    if (!done && q_exp.size() > 0) begin
      bit e;
      e = q_exp.pop_front();
      n_vec++;
      if (pwm_out !== e) begin
        n_bad++;
        $display("FAIL %s: pwm_out=%0b expected %0b at %0t", cur_tag, pwm_out, e, $time);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_high(int len, output int n);
    n = 0;
    repeat (len) begin
      @(negedge clk);
      n += int'(pwm_out);
    end
  endtask

  task automatic restart(input int cmp, input int ps, input bit pol, input bit sel);
    @(negedge clk);
    cfg_cmp = 8'(cmp); cfg_psel = 3'(ps); cfg_pol = pol; cfg_clksel = sel;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic duty(string tag, int cmp, int ps, bit pol, int len, int exp);
    int n;
    cur_tag = tag;
    restart(cmp, ps, pol, 1'b0);
    count_high(len, n);
    check(tag, n, exp);
  endtask

  initial begin
    int n;
    bit held;
    // R1: reset state for both polarities
    cur_tag = "R1 reset";
    repeat (2) @(negedge clk);
    cfg_pol = 1'b1; @(negedge clk);
    check("R1 reset pol1 inactive low", int'(pwm_out), 0);
    cfg_pol = 1'b0; @(negedge clk);
    check("R1 reset pol0 inactive high", int'(pwm_out), 1);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    duty("R2 cmp100 pol1", 100, 0, 1'b1, 256, 100);
    duty("R2 cmp255 max duty", 255, 0, 1'b1, 256, 255);
    duty("R2 cmp1 pol1", 1, 0, 1'b1, 256, 1);
    duty("R3 cmp64 pol0", 64, 0, 1'b0, 256, 192);
    duty("R3 cmp255 pol0", 255, 0, 1'b0, 256, 1);
    duty("R4 cmp0 pol1", 0, 0, 1'b1, 256, 0);
    duty("R4 cmp0 pol0", 0, 0, 1'b0, 256, 256);
    duty("R5 ps2 cmp128", 128, 2, 1'b1, 1024, 512);
    duty("R5 ps6 cmp10", 10, 6, 1'b1, 16384, 640);
    duty("R6 ps7 saturates", 10, 7, 1'b1, 16384, 640);

    // R7: mid-period change waits for the wrap
    cur_tag = "R7 shadow";
    restart(200, 0, 1'b1, 1'b0);
    repeat (50) @(negedge clk);
    cfg_cmp = 8'd20;
    repeat (100) @(negedge clk);
    check("R7 old cmp still active", int'(pwm_out), 1);
    repeat (150) @(negedge clk);
    check("R7 new cmp after wrap", int'(pwm_out), 0);

    // R8: auxiliary tick source
    cur_tag = "R8 aux source";
    aux_en = 1'b1;
    restart(128, 0, 1'b1, 1'b1);
    count_high(1024, n);
    check("R8 aux duty", n, 512);
    aux_en = 1'b0;
    repeat (4) @(negedge clk);
    held = pwm_out;
    count_high(300, n);
    check("R8 idle aux freezes output", n, held ? 300 : 0);
    cfg_clksel = 1'b0;
    cur_tag = "R8 back to clk";
    repeat (600) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule